// File: doc/BRIEF.md
# Microcoded SDRAM Command Sequencer

This block drives the control pins of an SDRAM from a sixteen-entry microcode table. Each 12-bit microword holds a fixed command (clock enable, the four active-low strobes, two bank bits, A10) and a 4-bit pointer to the next microword. Without outside influence the sequencer follows these pointers, so multi-step sequences such as self-refresh entry and exit run unattended. A host-side controller presents requests (activate, read, write, precharge, refresh, mode set). A request that the current microword allows is accepted at once: `req_ack` rises in that cycle and the next microword becomes the one that serves the request. A request that the current microword does not allow is dropped.

The request's bank, A10 and low address bits are latched when accepted. They are then ORed into the bank and A10 pins, or passed onto A0–A9, for the microwords that need dynamic address bits: activate, read, write and mode set. The SDRAM side runs at twice the host bus clock with CAS latency 2. Data transfer, host bus translation and the refresh interval timer sit outside this block.

States, with the micro-address of each: IDLE (0, NOP, chains to SR_ENTER), SR_ENTER (1, self-refresh entry, chains to SR_EXIT), SR_EXIT (2, NOP that ends refresh, chains to IDLE), MODE (3, mode-register set, chains to IDLE), DESEL (4, chip deselected, loops, entered on reset), PRE_B0..PRE_B3 (5–8, precharge of bank 0–3, chain to IDLE), ACT (9, activate, loops), READ (0xA) and WRITE (0xB), both chaining to ACT, and SPARE0..SPARE3 (0xC–0xF, NOP, chain to IDLE, never reached). Request-driven transitions: IDLE→ACT on activate, IDLE→SR_ENTER on refresh, IDLE/DESEL→MODE on mode set, IDLE/DESEL/ACT→PRE_Bn on precharge, ACT→READ on read, ACT→WRITE on write.

Top module: `sdram_ucode_seq`

## Requirements
- R1: After reset the pins show deselect (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n` high, `sd_cke` high, `sd_ba`, `sd_a10`, `sd_alo` zero). This holds until a mode-set or precharge request is accepted.
- R2: In IDLE with no request accepted, the pins show NOP (`sd_cke` high, `sd_cs_n` low, the other strobes high) for one cycle. Self-refresh entry follows for exactly one cycle (`sd_cke` low; `sd_cs_n`, `sd_ras_n`, `sd_cas_n` low; `sd_we_n` high). Then comes one NOP cycle with `sd_cke` high, and then IDLE again.
- R3: No request is accepted during the self-refresh entry cycle or the cycle that ends it.
- R4: A mode-set request is accepted in IDLE or DESEL. In the next cycle all four strobes are low, `sd_cke` is high, bank and A10 are zero and `sd_alo` equals the accepted `req_addr`. IDLE follows.
- R5: An activate request is accepted only in IDLE. In the next cycle `sd_cs_n` and `sd_ras_n` are low, `sd_cas_n` and `sd_we_n` are high, `sd_ba`=`req_bank`, `sd_a10`=`req_a10` and `sd_alo`=`req_addr`.
- R6: ACT keeps presenting the activate command until a read, write or precharge is accepted. Activate, refresh and mode requests made there are ignored and leave the pins unchanged.
- R7: Read (`sd_cas_n` low, `sd_ras_n` and `sd_we_n` high) and write (`sd_cas_n` and `sd_we_n` low, `sd_ras_n` high) are accepted only in ACT. Each shows `sd_ba`=`req_bank`, `sd_alo`=`req_addr` and `sd_a10` zero for one cycle, then ACT returns with the latest latched bank and address and the A10 of the activate.
- R8: A precharge is accepted in IDLE, DESEL or ACT. The next cycle shows `sd_cs_n`, `sd_ras_n` and `sd_we_n` low, `sd_cas_n` high, `sd_ba`=`req_bank`, and A10 and `sd_alo` zero. IDLE follows.
- R9: A refresh request is accepted only in IDLE and leads to the self-refresh entry cycle next.
- R10: `req_kind` is encoded activate=0, read=1, write=2, precharge=3, refresh=4, mode=5; codes 6 and 7 are never accepted. `req_ack` is high in exactly the cycle a request is accepted. A refused request changes neither the sequence nor the latched fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-side clock (twice the host bus rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Request code (see R10) |
| req_bank | input | 2 | Bank for activate, read, write, precharge |
| req_a10 | input | 1 | A10 value ORed in during activate |
| req_addr | input | ALO_W (10) | Row, column or mode value for A0–A9 |
| req_ack | output | 1 | Request accepted this cycle |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a10 | output | 1 | Address bit 10 |
| sd_alo | output | ALO_W (10) | Address bits A0–A9 |

## Verification
The two functions that share a cycle are the microword's own next-address chain and the request break-in. In IDLE the chain points at self-refresh entry, so an activate, mode set or precharge presented there must override the chain, while a request presented in SR_ENTER or SR_EXIT must lose to it. The bench presents requests in exactly those cycles and in the one-cycle read and write states. A scoreboard compares the pins in the following cycle, and the combinational acknowledge is checked in the request cycle, so both who won and the merged bank, A10 and address bits are judged.

// File: rtl/sdram_useq_pkg.sv
package sdram_useq_pkg;

    localparam int UA_W = 4;
    localparam int BA_W = 2;

    typedef enum logic [UA_W-1:0] {
        UA_IDLE     = 4'h0,
        UA_SR_ENTER = 4'h1,
        UA_SR_EXIT  = 4'h2,
        UA_MODE     = 4'h3,
        UA_DESEL    = 4'h4,
        UA_PRE_B0   = 4'h5,
        UA_PRE_B1   = 4'h6,
        UA_PRE_B2   = 4'h7,
        UA_PRE_B3   = 4'h8,
        UA_ACT      = 4'h9,
        UA_READ     = 4'hA,
        UA_WRITE    = 4'hB,
        UA_SPARE0   = 4'hC,
        UA_SPARE1   = 4'hD,
        UA_SPARE2   = 4'hE,
        UA_SPARE3   = 4'hF
    } uaddr_e;

    typedef enum logic [2:0] {
        RQ_ACT     = 3'd0,
        RQ_READ    = 3'd1,
        RQ_WRITE   = 3'd2,
        RQ_PRE     = 3'd3,
        RQ_REFRESH = 3'd4,
        RQ_MODE    = 3'd5
    } req_e;

    typedef struct packed {
        logic            cke;
        logic            a10;
        logic [BA_W-1:0] ba;
        logic            cs_n;
        logic            ras_n;
        logic            cas_n;
        logic            we_n;
    } ucmd_t;

    typedef struct packed {
        logic [UA_W-1:0] nxt;
        ucmd_t           cmd;
    } uword_t;

    function automatic ucmd_t mk_cmd(input logic cke, input logic cs_n,
                                     input logic ras_n, input logic cas_n,
                                     input logic we_n, input logic [BA_W-1:0] ba,
                                     input logic a10);
        ucmd_t c;
        c.cke   = cke;
        c.a10   = a10;
        c.ba    = ba;
        c.cs_n  = cs_n;
        c.ras_n = ras_n;
        c.cas_n = cas_n;
        c.we_n  = we_n;
        return c;
    endfunction

    function automatic uword_t mk_word(input uaddr_e nxt, input ucmd_t cmd);
        uword_t w;
        w.nxt = nxt;
        w.cmd = cmd;
        return w;
    endfunction

endpackage

// File: rtl/sdram_ucode_rom.sv
module sdram_ucode_rom
    import sdram_useq_pkg::*;
(
    input  uaddr_e addr,
    output uword_t word
);

    ucmd_t c_nop;
    ucmd_t c_desel;
    ucmd_t c_sr_enter;
    ucmd_t c_mode;
    ucmd_t c_act;
    ucmd_t c_read;
    ucmd_t c_write;

    always_comb begin
        c_nop      = mk_cmd(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        c_desel    = mk_cmd(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
        c_sr_enter = mk_cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b0);
        c_mode     = mk_cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        c_act      = mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b0);
        c_read     = mk_cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
        c_write    = mk_cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    end

    always_comb begin
        unique case (addr)
            UA_IDLE:     word = mk_word(UA_SR_ENTER, c_nop);
            UA_SR_ENTER: word = mk_word(UA_SR_EXIT,  c_sr_enter);
            UA_SR_EXIT:  word = mk_word(UA_IDLE,     c_nop);
            UA_MODE:     word = mk_word(UA_IDLE,     c_mode);
            UA_DESEL:    word = mk_word(UA_DESEL,    c_desel);
            UA_PRE_B0:   word = mk_word(UA_IDLE, mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
            UA_PRE_B1:   word = mk_word(UA_IDLE, mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0));
            UA_PRE_B2:   word = mk_word(UA_IDLE, mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0));
            UA_PRE_B3:   word = mk_word(UA_IDLE, mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0));
            UA_ACT:      word = mk_word(UA_ACT,      c_act);
            UA_READ:     word = mk_word(UA_ACT,      c_read);
            UA_WRITE:    word = mk_word(UA_ACT,      c_write);
            default:     word = mk_word(UA_IDLE,     c_nop);
        endcase
    end

endmodule

// File: rtl/sdram_useq_ctl.sv
module sdram_useq_ctl
    import sdram_useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  req_e            req_kind,
    input  logic [BA_W-1:0] req_bank,
    input  logic [UA_W-1:0] rom_nxt,
    output uaddr_e          uaddr,
    output logic            req_ack
);

    uaddr_e nxt_state;
    uaddr_e pre_target;

    always_comb begin
        pre_target = uaddr_e'(UA_W'(UA_PRE_B0) + UA_W'(req_bank));
    end

    // Break-in logic: a permitted request overrides the chained pointer.
    always_comb begin
        req_ack   = 1'b0;
        nxt_state = uaddr_e'(rom_nxt);
        if (req_valid) begin
            unique case (uaddr)
                UA_IDLE: begin
                    unique case (req_kind)
                        RQ_ACT:     begin req_ack = 1'b1; nxt_state = UA_ACT;      end
                        RQ_REFRESH: begin req_ack = 1'b1; nxt_state = UA_SR_ENTER; end
                        RQ_MODE:    begin req_ack = 1'b1; nxt_state = UA_MODE;     end
                        RQ_PRE:     begin req_ack = 1'b1; nxt_state = pre_target;  end
                        default:    ;
                    endcase
                end
                UA_DESEL: begin
                    unique case (req_kind)
                        RQ_MODE:    begin req_ack = 1'b1; nxt_state = UA_MODE;     end
                        RQ_PRE:     begin req_ack = 1'b1; nxt_state = pre_target;  end
                        default:    ;
                    endcase
                end
                UA_ACT: begin
                    unique case (req_kind)
                        RQ_READ:    begin req_ack = 1'b1; nxt_state = UA_READ;     end
                        RQ_WRITE:   begin req_ack = 1'b1; nxt_state = UA_WRITE;    end
                        RQ_PRE:     begin req_ack = 1'b1; nxt_state = pre_target;  end
                        default:    ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uaddr <= UA_DESEL;
        else        uaddr <= nxt_state;
    end

    AST_DESEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_DESEL && !req_ack) |=> uaddr == UA_DESEL); // R1
    AST_SR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UA_SR_ENTER |=> uaddr == UA_SR_EXIT); // R3
    AST_SR_EXIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UA_SR_EXIT |=> uaddr == UA_IDLE); // R3
    AST_ACT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_ACT && !req_ack) |=> uaddr == UA_ACT); // R6
    AST_RW_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_READ || uaddr == UA_WRITE) |=> uaddr == UA_ACT); // R7
    AST_PRE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr >= UA_PRE_B0 && uaddr <= UA_PRE_B3) |=> uaddr == UA_IDLE); // R8

endmodule

// File: rtl/sdram_useq_merge.sv
module sdram_useq_merge
    import sdram_useq_pkg::*;
#(
    parameter int ALO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  uaddr_e           uaddr,
    input  ucmd_t            cmd,
    input  logic             req_ack,
    input  req_e             req_kind,
    input  logic [BA_W-1:0]  req_bank,
    input  logic             req_a10,
    input  logic [ALO_W-1:0] req_addr,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic             sd_a10,
    output logic [ALO_W-1:0] sd_alo
);

    logic [BA_W-1:0]  lat_ba;
    logic             lat_a10;
    logic [ALO_W-1:0] lat_alo;
    logic             or_ba;
    logic             or_a10;
    logic             show_alo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_ba  <= '0;
            lat_a10 <= 1'b0;
            lat_alo <= '0;
        end else if (req_ack) begin
            if (req_kind == RQ_ACT || req_kind == RQ_READ || req_kind == RQ_WRITE)
                lat_ba <= req_bank;
            if (req_kind == RQ_ACT)
                lat_a10 <= req_a10;
            if (req_kind == RQ_ACT || req_kind == RQ_READ ||
                req_kind == RQ_WRITE || req_kind == RQ_MODE)
                lat_alo <= req_addr;
        end
    end

    always_comb begin
        or_ba    = (uaddr == UA_ACT) || (uaddr == UA_READ) || (uaddr == UA_WRITE);
        or_a10   = (uaddr == UA_ACT);
        show_alo = or_ba || (uaddr == UA_MODE);
        sd_cke   = cmd.cke;
        sd_cs_n  = cmd.cs_n;
        sd_ras_n = cmd.ras_n;
        sd_cas_n = cmd.cas_n;
        sd_we_n  = cmd.we_n;
        sd_ba    = cmd.ba  | (or_ba  ? lat_ba  : '0);
        sd_a10   = cmd.a10 | (or_a10 ? lat_a10 : 1'b0);
        sd_alo   = show_alo ? lat_alo : '0;
    end

    AST_DESEL_KEEPS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cs_n |-> sd_cke); // R1
    AST_SR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |=> sd_cke); // R2
    AST_MODE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
        |-> sd_alo == $past(req_addr)); // R4
    AST_ACT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_ack) && $past(req_kind) == RQ_ACT) |-> sd_ba == $past(req_bank)); // R5

endmodule

// File: rtl/sdram_ucode_seq.sv
module sdram_ucode_seq
    import sdram_useq_pkg::*;
#(
    parameter int ALO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [1:0]       req_bank,
    input  logic             req_a10,
    input  logic [ALO_W-1:0] req_addr,
    output logic             req_ack,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [1:0]       sd_ba,
    output logic             sd_a10,
    output logic [ALO_W-1:0] sd_alo
);

    uaddr_e uaddr;
    uword_t word;
    req_e   kind;

    always_comb kind = req_e'(req_kind);

    sdram_ucode_rom u_rom (
        .addr (uaddr),
        .word (word)
    );

    sdram_useq_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (kind),
        .req_bank  (req_bank),
        .rom_nxt   (word.nxt),
        .uaddr     (uaddr),
        .req_ack   (req_ack)
    );

    sdram_useq_merge #(.ALO_W(ALO_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .uaddr    (uaddr),
        .cmd      (word.cmd),
        .req_ack  (req_ack),
        .req_kind (kind),
        .req_bank (req_bank),
        .req_a10  (req_a10),
        .req_addr (req_addr),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_a10   (sd_a10),
        .sd_alo   (sd_alo)
    );

endmodule

// File: tb/sdram_ucode_seq_test.sv
`timescale 1ns/1ps
module sdram_ucode_seq_test;

    localparam int AW = 10;
    localparam logic [2:0] K_ACT = 3'd0, K_RD = 3'd1, K_WR = 3'd2,
                           K_PRE = 3'd3, K_REF = 3'd4, K_MODE = 3'd5, K_BAD = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic [1:0] req_bank = '0;
    logic req_a10 = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ack, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
    logic [1:0] sd_ba;
    logic [AW-1:0] sd_alo;

    int checks = 0;
    int errs = 0;
    logic [18:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    sdram_ucode_seq #(.ALO_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_bank(req_bank), .req_a10(req_a10), .req_addr(req_addr),
        .req_ack(req_ack), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a10(sd_a10), .sd_alo(sd_alo)
    );

    function automatic logic [18:0] pk(input logic cke, input logic cs, input logic ras,
                                       input logic cas, input logic we, input logic [1:0] ba,
                                       input logic a10, input logic [AW-1:0] alo);
        return {cke, cs, ras, cas, we, ba, a10, alo};
    endfunction
    function automatic logic [18:0] e_des();  return pk(1,1,1,1,1,2'd0,0,'0); endfunction
    function automatic logic [18:0] e_nop();  return pk(1,0,1,1,1,2'd0,0,'0); endfunction
    function automatic logic [18:0] e_sre();  return pk(0,0,0,0,1,2'd0,0,'0); endfunction
    function automatic logic [18:0] e_mode(input logic [AW-1:0] a); return pk(1,0,0,0,0,2'd0,0,a); endfunction
    function automatic logic [18:0] e_act(input logic [1:0] b, input logic t, input logic [AW-1:0] a);
        return pk(1,0,0,1,1,b,t,a);
    endfunction
    function automatic logic [18:0] e_rd(input logic [1:0] b, input logic [AW-1:0] a); return pk(1,0,1,0,1,b,0,a); endfunction
    function automatic logic [18:0] e_wr(input logic [1:0] b, input logic [AW-1:0] a); return pk(1,0,1,0,0,b,0,a); endfunction
    function automatic logic [18:0] e_pre(input logic [1:0] b); return pk(1,0,0,1,0,b,0,'0); endfunction

    function automatic logic [18:0] pins();
        return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a10, sd_alo};
    endfunction

    // Monitor: compares the pins one edge after each driven cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [18:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pins() !== e) begin
                    errs++;
                    $display("FAIL %s pins: actual=%h expected=%h", t, pins(), e);
                end
            end
        end
    end

    // Driver: presents one cycle of request, checks ack, queues next-cycle pins.
    task automatic step(input logic v, input logic [2:0] k, input logic [1:0] b,
                        input logic t, input logic [AW-1:0] a, input logic eack,
                        input logic [18:0] ecmd, input string tag);
        @(negedge clk);
        req_valid = v; req_kind = k; req_bank = b; req_a10 = t; req_addr = a;
        #1;
        checks++;
        if (req_ack !== eack) begin
            errs++;
            $display("FAIL %s ack: actual=%b expected=%b", tag, req_ack, eack);
        end
        exp_q.push_back(ecmd);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [18:0] ecmd, input string tag);
        step(0, K_ACT, 2'd0, 0, '0, 0, ecmd, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        checks++;
        if (pins() !== e_des()) begin
            errs++;
            $display("FAIL R1 reset pins: actual=%h expected=%h", pins(), e_des());
        end
        rst_n = 1;
    endtask

    initial begin
        #800000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: deselect holds, refuses read
        step(1, K_RD, 2'd1, 0, 10'h011, 0, e_des(), "R1 desel refuses read");
        idle(e_des(), "R1 desel holds");
        // R4: mode set from deselect
        step(1, K_MODE, 2'd0, 0, 10'h2A5, 1, e_mode(10'h2A5), "R4 mode from desel");
        idle(e_nop(), "R4 mode returns idle");
        // R2: idle chains into self refresh
        idle(e_sre(), "R2 idle chains to sr entry");
        // R3: no break-in during refresh pair
        step(1, K_RD, 2'd1, 0, 10'h011, 0, e_nop(), "R3 sr entry locked");
        step(1, K_ACT, 2'd1, 1, 10'h011, 0, e_nop(), "R3 sr exit locked");
        // R5: activate overrides the chain from idle
        step(1, K_ACT, 2'd2, 1, 10'h155, 1, e_act(2'd2, 1, 10'h155), "R5 activate");
        idle(e_act(2'd2, 1, 10'h155), "R6 act parks");
        step(1, K_ACT, 2'd0, 0, 10'h0F0, 0, e_act(2'd2, 1, 10'h155), "R6 act ignored in act");
        step(1, K_MODE, 2'd0, 0, 10'h0F0, 0, e_act(2'd2, 1, 10'h155), "R6 mode ignored in act");
        // R7: read and write
        step(1, K_RD, 2'd1, 0, 10'h033, 1, e_rd(2'd1, 10'h033), "R7 read");
        step(1, K_WR, 2'd0, 0, 10'h044, 0, e_act(2'd1, 1, 10'h033), "R7 read returns to act");
        step(1, K_WR, 2'd3, 0, 10'h3FF, 1, e_wr(2'd3, 10'h3FF), "R7 write");
        idle(e_act(2'd3, 1, 10'h3FF), "R7 write returns to act");
        // R8: precharge from act and from idle
        step(1, K_PRE, 2'd3, 0, 10'h001, 1, e_pre(2'd3), "R8 precharge from act");
        step(1, K_REF, 2'd0, 0, '0, 0, e_nop(), "R8 precharge returns idle");
        step(1, K_PRE, 2'd0, 0, '0, 1, e_pre(2'd0), "R8 precharge from idle");
        idle(e_nop(), "R8 back to idle");
        // R9: refresh request from idle
        step(1, K_REF, 2'd0, 0, '0, 1, e_sre(), "R9 refresh accepted");
        idle(e_nop(), "R2 sr exit");
        idle(e_nop(), "R2 idle again");
        // R10: codes not allowed in idle are refused
        step(1, K_RD, 2'd1, 0, 10'h077, 0, e_sre(), "R10 read refused in idle");
        idle(e_nop(), "R2 sr exit");
        idle(e_nop(), "R2 idle");
        step(1, K_BAD, 2'd1, 1, 10'h077, 0, e_sre(), "R10 unused code refused");
        idle(e_nop(), "R2 sr exit");
        idle(e_nop(), "R2 idle");
        step(1, K_WR, 2'd1, 0, 10'h077, 0, e_sre(), "R10 write refused in idle");
        idle(e_nop(), "R2 sr exit");
        idle(e_nop(), "R2 idle");
        step(1, K_MODE, 2'd0, 0, 10'h001, 1, e_mode(10'h001), "R4 mode from idle");
        idle(e_nop(), "R4 mode returns idle");
        step(1, K_ACT, 2'd1, 0, 10'h2C3, 1, e_act(2'd1, 0, 10'h2C3), "R5 activate a10 low");
        idle(e_act(2'd1, 0, 10'h2C3), "R6 act parks");
        repeat (3) @(posedge clk);
        // R1/R8: precharge from deselect after a second reset
        do_reset();
        step(1, K_PRE, 2'd2, 1, 10'h3AA, 1, e_pre(2'd2), "R8 precharge from desel");
        idle(e_nop(), "R8 precharge returns idle");
        idle(e_sre(), "R2 chain after precharge");
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule